// File: doc/BRIEF.md
# Real-Time Clock Divider and Update Sequencer

This block sits between a 32.768 kHz time-base enable and the calendar counters of a real-time clock. It divides the base enable down to a once-per-second update strobe and raises a busy flag for a short window before each update. That flag lets software avoid reading the time while it is changing. A second divider chain produces a periodic tick. Its rate is chosen by a 4-bit code, and each step of the code halves the frequency.

A control register written through a single write-enable holds the 3-bit divider mode and the 4-bit rate code. One divider mode holds both chains at a defined starting point. Leaving that mode starts the one-second phase at its midpoint, so the first update lands half a second after release. A separate freeze input lets software rewrite the time. While it is high, the update strobe and the busy flag are masked, but the divider keeps its cadence. The calendar counters, alarm compare and host bus are outside this block. There is no streaming data path, so every pin is a plain level or a one-cycle pulse.

Top module: `rtc_update_ctl`

## Requirements
- R1: While `rst_n` is low and right after it rises, `sec_strobe`, `upd_busy` and `rate_tick` are 0, and the register holds divider mode 3'b111 with rate code 0.
- R2: Divider modes 3'b110 and 3'b111 hold the second phase at its midpoint and the periodic count at zero. In these modes no `sec_strobe`, no `rate_tick` and no `upd_busy` occur.
- R3: In divider mode 3'b010, the first `sec_strobe` comes on the 2^(SEC_LOG2-1)-th counted base enable after the mode takes effect. Later strobes follow every 2^SEC_LOG2 base enables. Each strobe lasts one clock.
- R4: `upd_busy` is 1 from the base enable that is UIP_LEN enables before an update until the clock edge on which that update's strobe is issued. That is UIP_LEN base periods, and the flag is 0 at every other time.
- R5: `upd_busy` is 0 in every cycle where `sec_strobe` is 1, so it can never stay high past the end of an update window.
- R6: A rate code r from 1 to 15 gives one `rate_tick` pulse per 2^(r-1) counted base enables.
- R7: Rate code 0 gives no `rate_tick` and clears the periodic count.
- R8: The length of each periodic interval is set by the rate code in force at that interval's first base enable. A rate code written mid-interval therefore applies from the following interval.
- R9: While `freeze_upd` is 1, `sec_strobe` and `upd_busy` stay 0, but the second phase keeps counting. Updates after release keep the original cadence.
- R10: Divider modes other than 3'b010, 3'b110 and 3'b111 stop both chains where they are. Returning to 3'b010 resumes from the stopped phase.
- R11: `cfg_div` and `cfg_rate` are captured only on a clock edge with `cfg_we` high and act from the following edge. Changes on those inputs without `cfg_we` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en | input | 1 | One-cycle enable at the 32.768 kHz base rate |
| cfg_we | input | 1 | Write enable for the control register |
| cfg_div | input | 3 | Divider mode to write |
| cfg_rate | input | 4 | Periodic rate code to write |
| freeze_upd | input | 1 | Masks updates while time is being set |
| sec_strobe | output | 1 | One-clock pulse when an update completes |
| upd_busy | output | 1 | High during the window before an update |
| rate_tick | output | 1 | One-clock periodic pulse |

## Verification
A register write acts on the second clock edge after `cfg_we` is sampled. `sec_strobe` and `rate_tick` are registered on the same edge as the base enable that completes a second or an interval. `upd_busy` follows the phase register and changes right after that edge. The bench keeps a step model that advances once per rising edge from the register contents in force before that edge, applies writes after the step, and compares all three outputs at every falling edge. Counted checks (first-update position, strobe and tick counts, window length in clocks) are expressed in base enables, as the requirements are, so they do not depend on how many clocks separate two enables.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    DIV_STOP = 2'd0,
    DIV_RUN  = 2'd1,
    DIV_HOLD = 2'd2
  } div_mode_e;

  localparam logic [MODE_W-1:0] MODE_RUN_CODE  = 3'b010;
  localparam logic [MODE_W-1:0] MODE_RESET_VAL = 3'b111;

  function automatic div_mode_e decode_mode(input logic [MODE_W-1:0] code);
    if (code == MODE_RUN_CODE)      return DIV_RUN;
    else if (code[2:1] == 2'b11)    return DIV_HOLD;
    else                            return DIV_STOP;
  endfunction

endpackage

// File: rtl/rtc_div_decode.sv
module rtc_div_decode
  import rtc_upd_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic              run_o,
  output logic              hold_o
);

  div_mode_e mode;

  always_comb begin
    mode   = decode_mode(mode_i);
    run_o  = (mode == DIV_RUN);
    hold_o = (mode == DIV_HOLD);
  end

endmodule

// File: rtl/rtc_sec_chain.sv
module rtc_sec_chain #(
  parameter int SEC_LOG2 = 15,
  parameter int UIP_LEN  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_i,
  input  logic run_i,
  input  logic hold_i,
  input  logic freeze_i,
  output logic upd_o,
  output logic busy_o
);

  localparam int SEC = 1 << SEC_LOG2;
  localparam logic [SEC_LOG2-1:0] PH_HALF = SEC_LOG2'(SEC / 2);
  localparam logic [SEC_LOG2-1:0] PH_LAST = SEC_LOG2'(SEC - 1);
  localparam logic [SEC_LOG2-1:0] PH_WIN  = SEC_LOG2'(SEC - UIP_LEN);

  logic [SEC_LOG2-1:0] phase;
  logic                at_last;

  assign at_last = (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_HALF;
      upd_o <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (hold_i) begin
        phase <= PH_HALF;
      end else if (run_i && base_i) begin
        if (at_last) begin
          phase <= '0;
          upd_o <= !freeze_i;
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  always_comb busy_o = run_i && !freeze_i && (phase >= PH_WIN);

  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && base_i && at_last) |=> !busy_o); // R5
  AST_UPD_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(busy_o)); // R4
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (!upd_o && phase == PH_HALF)); // R2
  AST_STOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !hold_i) |=> $stable(phase)); // R10

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_i,
  input  logic              run_i,
  input  logic              hold_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);

  localparam int PER_W = (1 << RATE_W) - 2;

  function automatic logic [PER_W-1:0] limit_of(input logic [RATE_W-1:0] r);
    logic [PER_W-1:0] l;
    for (int i = 0; i < PER_W; i++) l[i] = (i < (int'(r) - 1));
    return l;
  endfunction

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] lim;
  logic [PER_W-1:0] lim_now;
  logic             at_start;

  assign at_start = (cnt == '0);
  assign lim_now  = at_start ? limit_of(rate_i) : lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      lim    <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (at_start) lim <= limit_of(rate_i);
      if (hold_i || rate_i == '0) begin
        cnt <= '0;
      end else if (run_i && base_i) begin
        if (cnt == lim_now) begin
          tick_o <= 1'b1;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_TICK_ON_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(base_i && run_i)); // R6
  AST_OFF_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i == '0 || hold_i) |=> (!tick_o && cnt == '0)); // R7
  AST_CNT_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !at_start |-> (cnt <= lim)); // R8

endmodule

// File: rtl/rtc_update_ctl.sv
module rtc_update_ctl
  import rtc_upd_pkg::*;
#(
  parameter int SEC_LOG2 = 15,
  parameter int UIP_LEN  = 8,
  parameter int RATE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_en,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_div,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              freeze_upd,
  output logic              sec_strobe,
  output logic              upd_busy,
  output logic              rate_tick
);

  logic [MODE_W-1:0] div_q;
  logic [RATE_W-1:0] rate_q;
  logic              run;
  logic              hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= MODE_RESET_VAL;
      rate_q <= '0;
    end else if (cfg_we) begin
      div_q  <= cfg_div;
      rate_q <= cfg_rate;
    end
  end

  rtc_div_decode u_dec (
    .mode_i (div_q),
    .run_o  (run),
    .hold_o (hold)
  );

  rtc_sec_chain #(
    .SEC_LOG2 (SEC_LOG2),
    .UIP_LEN  (UIP_LEN)
  ) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_i   (base_en),
    .run_i    (run),
    .hold_i   (hold),
    .freeze_i (freeze_upd),
    .upd_o    (sec_strobe),
    .busy_o   (upd_busy)
  );

  rtc_periodic #(
    .RATE_W (RATE_W)
  ) u_per (
    .clk    (clk),
    .rst_n  (rst_n),
    .base_i (base_en),
    .run_i  (run),
    .hold_i (hold),
    .rate_i (rate_q),
    .tick_o (rate_tick)
  );

  AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (div_q == $past(cfg_div) && rate_q == $past(cfg_rate))); // R11
  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(div_q) && $stable(rate_q))); // R11
  AST_FREEZE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |-> !$past(freeze_upd)); // R9
  AST_STROBE_EXCL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |-> !upd_busy); // R5

endmodule

// File: tb/sim_rtc_update_ctl.sv
`timescale 1ns/1ps
module sim_rtc_update_ctl;

  localparam int SL   = 9;
  localparam int SEC  = 1 << SL;
  localparam int HALF = SEC / 2;
  localparam int UL   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_div = 3'b000;
  logic [3:0] cfg_rate = 4'd0;
  logic       freeze_upd = 1'b0;
  logic       sec_strobe, upd_busy, rate_tick;

  rtc_update_ctl #(.SEC_LOG2(SL), .UIP_LEN(UL), .RATE_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .cfg_we(cfg_we),
    .cfg_div(cfg_div), .cfg_rate(cfg_rate), .freeze_upd(freeze_upd),
    .sec_strobe(sec_strobe), .upd_busy(upd_busy), .rate_tick(rate_tick)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state, advanced once per rising edge
  int         m_ph = HALF, m_pc = 0, m_lim = 0, cyc = 0;
  logic [2:0] m_div = 3'b111;
  logic [3:0] m_rate = 4'd0;
  string      tag = "R1";

  // measurements since the last clr()
  int c_upd, c_busy, c_tick, c_rb, first_upd, t1, t2;

  function automatic int lim_of(input int r);
    return (r == 0) ? 0 : (1 << (r - 1)) - 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clr();
    c_upd = 0; c_busy = 0; c_tick = 0; c_rb = 0;
    first_upd = -1; t1 = -1; t2 = -1;
  endtask

  task automatic cycle();
    bit b, s, run, hold, e_upd, e_tick, e_busy;
    int le;
    @(negedge clk);
    b = base_en; s = freeze_upd;
    run  = (m_div == 3'b010);
    hold = (m_div[2:1] == 2'b11);
    e_upd = 0; e_tick = 0;
    if (hold) m_ph = HALF;
    else if (run && b) begin
      if (m_ph == SEC - 1) begin m_ph = 0; e_upd = !s; end
      else m_ph = m_ph + 1;
    end
    le = (m_pc == 0) ? lim_of(int'(m_rate)) : m_lim;
    if (m_pc == 0) m_lim = le;
    if (hold || m_rate == 0) m_pc = 0;
    else if (run && b) begin
      if (m_pc == le) begin e_tick = 1; m_pc = 0; end
      else m_pc = m_pc + 1;
    end
    if (run && b) c_rb++;
    if (cfg_we) begin m_div = cfg_div; m_rate = cfg_rate; end
    e_busy = (m_div == 3'b010) && !s && (m_ph >= SEC - UL);
    chk({tag, "/R3 sec_strobe"}, int'(sec_strobe), int'(e_upd));
    chk({tag, "/R4 upd_busy"},  int'(upd_busy),  int'(e_busy));
    chk({tag, "/R6 rate_tick"}, int'(rate_tick), int'(e_tick));
    if (sec_strobe) begin
      chk("R5 busy low on strobe", int'(upd_busy), 0);
      c_upd++;
      if (first_upd < 0) first_upd = c_rb;
    end
    if (upd_busy) c_busy++;
    if (rate_tick) begin
      c_tick++;
      if (t1 < 0) t1 = c_rb; else if (t2 < 0) t2 = c_rb;
    end
    cfg_we = 1'b0;
    cyc++;
    base_en = (cyc % 2 == 0);
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr(input logic [2:0] d, input logic [3:0] r);
    cfg_we = 1'b1; cfg_div = d; cfg_rate = r;
    cycle();
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    chk("R1 strobe in reset", int'(sec_strobe), 0);
    chk("R1 busy in reset",   int'(upd_busy), 0);
    chk("R1 tick in reset",   int'(rate_tick), 0);
    rst_n = 1'b1;
    tag = "R1";
    cycle();
    chk("R1 strobe after reset", int'(sec_strobe), 0);

    // R2: reset-value hold mode
    tag = "R2"; clr();
    run_n(200);
    chk("R2 no strobe in hold", c_upd, 0);
    chk("R2 no busy in hold", c_busy, 0);

    // R3/R4/R7/R11: release, rate 0, stray field changes without write
    tag = "R3";
    wr(3'b010, 4'd0); clr();
    cfg_div = 3'b111; cfg_rate = 4'd5;
    run_n(2 * (HALF + 2 * SEC) + 4);
    chk("R3 first update position", first_upd, HALF);
    chk("R3 update count", c_upd, 3);
    chk("R4 busy clocks per window", c_busy, 3 * UL * 2);
    chk("R7 no tick at rate 0", c_tick, 0);
    chk("R11 unwritten fields ignored", c_upd + c_tick, 3);

    // R6: sweep of rate codes
    tag = "R6";
    for (int r = 1; r <= 12; r++) begin
      wr(3'b010, 4'd0); wr(3'b010, 4'(r)); clr();
      run_n(6 * (1 << (r - 1)) + 4);
      chk($sformatf("R6 tick count rate %0d", r), c_tick, c_rb / (1 << (r - 1)));
    end
    wr(3'b010, 4'd0); wr(3'b010, 4'd13); clr();
    run_n(4 * 4096 + 4);
    chk("R6 tick count rate 13", c_tick, c_rb / 4096);
    wr(3'b010, 4'd0); wr(3'b010, 4'd15); clr();
    run_n(2 * 16384 + 4);
    chk("R6 tick count rate 15", c_tick, c_rb / 16384);

    // R8: rate change inside an interval
    tag = "R8";
    wr(3'b010, 4'd0); wr(3'b010, 4'd4); clr();
    while (c_rb < 3) cycle();
    wr(3'b010, 4'd2);
    while (t2 < 0) cycle();
    chk("R8 old period finishes", t1, 8);
    chk("R8 new period next", t2, 10);

    // R9: freeze masks updates, cadence continues
    tag = "R9";
    wr(3'b010, 4'd0); clr();
    freeze_upd = 1'b1;
    run_n(4 * SEC);
    chk("R9 no strobe while frozen", c_upd, 0);
    chk("R9 no busy while frozen", c_busy, 0);
    freeze_upd = 1'b0; clr();
    run_n(2 * SEC + 4);
    chk("R9 one update after release", c_upd, 1);

    // R10 with R2 code 110: stop mode keeps phase
    tag = "R10";
    wr(3'b110, 4'd0); wr(3'b010, 4'd0); clr();
    while (c_rb < 100) cycle();
    wr(3'b000, 4'd0);
    run_n(300);
    chk("R10 no strobe while stopped", c_upd, 0);
    wr(3'b010, 4'd0);
    while (c_upd == 0) cycle();
    chk("R10 resume keeps phase", first_upd, HALF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule